// File: doc/BRIEF.md
# Timer Trigger Output Mode Selector

This block produces the two trigger outputs of a general-purpose timer: a main trigger and an auxiliary trigger. Each output is steered by its own mode field in a control register. A mode either passes a level through (counter enable, a compare reference) or forms a pulse from an event (counter reset, counter update, channel 1 match, or chosen edges of the compare references). The counter, prescaler, compare channels and pin logic sit outside the block and reach it as inputs.

The main trigger has a 3-bit mode field with eight codes. The auxiliary trigger has a 4-bit field with sixteen codes. Its upper codes pass the fifth and sixth compare references as levels, or form pulses from rising or falling edges of one or two references joined by OR. A build parameter removes the auxiliary field. When it is absent, writes to that field have no effect and the field reads back as zero, so software can tell whether the feature is present.

Both outputs are registered. The trigger seen after a clock edge reflects the inputs and modes just before that edge. Edges are found by comparing each compare reference with a registered copy of its previous value.

Top module: `trig_mode_sel`

## Requirements
- R1: The control register holds the main mode in bits 6:4 and the auxiliary mode in bits 23:20. All other read-back bits are zero. After reset both fields are zero.
- R2: A write (`ctrl_we` high) updates the read-back value at the next clock edge. The trigger output computed at the write edge still uses the old mode; the new mode steers the trigger computed at the following edge.
- R3: With `HAS_AUX` = 0, writes to bits 23:20 are ignored. Those bits read zero, and the auxiliary trigger behaves as code 0.
- R4: Codes 0, 1 and 2 make a trigger follow the counter reset event, the counter enable and the counter update event respectively, one clock later.
- R5: Code 3 makes a trigger follow the channel 1 match event (`cc1_match`), one clock later.
- R6: Codes 4 to 7 pass `oc_ref[0]` to `oc_ref[3]` as levels, one clock later. Auxiliary codes 8 and 9 pass `oc_ref[4]` and `oc_ref[5]`.
- R7: Auxiliary code 10 pulses on any edge of `oc_ref[3]`. Code 11 pulses on any edge of `oc_ref[5]`.
- R8: Auxiliary codes 12/13 pulse on a rise of `oc_ref[3]` OR a rise/fall of `oc_ref[5]`. Codes 14/15 do the same with `oc_ref[4]` in place of `oc_ref[3]`. A change of the other polarity gives no pulse.
- R9: An edge-derived pulse lasts exactly one clock. Two qualifying edges in the same cycle give a single pulse.
- R10: Both triggers are configured and driven independently in the same cycle.
- R11: While `rst_n` is low, both triggers are low and the edge history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst_evt | input | 1 | Counter reset event |
| cnt_en | input | 1 | Counter enable level |
| cnt_upd_evt | input | 1 | Counter update event |
| cc1_match | input | 1 | Channel 1 compare match event |
| oc_ref | input | 6 | Compare reference levels, channel 1 in bit 0 |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl_rdata | output | 32 | Control register read-back |
| trig_main | output | 1 | Main trigger output |
| trig_aux | output | 1 | Auxiliary trigger output |

## Verification
Several behaviours are checked on every cycle: the one-clock write latency of both fields, zero reserved bits, and the absent-field read-back. The one-clock follow of the update and level modes and the rise-or-rise pulse of code 12 are also checked on every cycle. The bench scenarios cover the rest. They walk every mode code with a chosen previous and present reference pattern. They show that a pulse ends after one clock, that coinciding edges merge, and that a wrong-polarity change is ignored. They also check the old-mode cycle at a write, the reset state, and a build without the auxiliary field.

// File: rtl/trig_mode_sel_pkg.sv
`timescale 1ns/1ps
package trig_mode_sel_pkg;

    localparam int NUM_REF  = 6;
    localparam int MODE_W   = 4;
    localparam int REG_W    = 32;

    typedef enum logic [MODE_W-1:0] {
        MD_RESET    = 4'd0,
        MD_ENABLE   = 4'd1,
        MD_UPDATE   = 4'd2,
        MD_CC1      = 4'd3,
        MD_LVL1     = 4'd4,
        MD_LVL2     = 4'd5,
        MD_LVL3     = 4'd6,
        MD_LVL4     = 4'd7,
        MD_LVL5     = 4'd8,
        MD_LVL6     = 4'd9,
        MD_ANY4     = 4'd10,
        MD_ANY6     = 4'd11,
        MD_R4_R6    = 4'd12,
        MD_R4_F6    = 4'd13,
        MD_R5_R6    = 4'd14,
        MD_R5_F6    = 4'd15
    } trig_mode_e;

    typedef struct packed {
        logic rst;
        logic en;
        logic upd;
        logic cc1;
    } cnt_evt_t;

    typedef struct packed {
        logic [NUM_REF-1:0] lvl;
        logic [NUM_REF-1:0] rise;
        logic [NUM_REF-1:0] fall;
    } ref_sig_t;

endpackage

// File: rtl/trig_mode_sel_ctrl.sv
`timescale 1ns/1ps
module trig_mode_sel_ctrl
    import trig_mode_sel_pkg::*;
#(
    parameter bit HAS_AUX  = 1'b1,
    parameter int MAIN_LSB = 4,
    parameter int MAIN_W   = 3,
    parameter int AUX_LSB  = 20,
    parameter int AUX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [MAIN_W-1:0] main_mode,
    output logic [AUX_W-1:0]  aux_mode,
    output logic [REG_W-1:0]  rdata
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_mode <= '0;
        end else if (we) begin
            main_mode <= wdata[MAIN_LSB +: MAIN_W];
        end
    end

    generate
        if (HAS_AUX) begin : g_aux_field
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    aux_mode <= '0;
                end else if (we) begin
                    aux_mode <= wdata[AUX_LSB +: AUX_W];
                end
            end
        end else begin : g_no_aux_field
            assign aux_mode = '0;
        end
    endgenerate

    always_comb begin
        rdata                     = '0;
        rdata[MAIN_LSB +: MAIN_W] = main_mode;
        rdata[AUX_LSB +: AUX_W]   = aux_mode;
    end

endmodule

// File: rtl/trig_mode_sel_edge.sv
`timescale 1ns/1ps
module trig_mode_sel_edge
    import trig_mode_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REF-1:0] ref_in,
    output ref_sig_t           sig
);

    logic [NUM_REF-1:0] hist_q;

    generate
        for (genvar i = 0; i < NUM_REF; i++) begin : g_hist
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q[i] <= 1'b0;
                end else begin
                    hist_q[i] <= ref_in[i];
                end
            end
            assign sig.rise[i] = ref_in[i] & ~hist_q[i];
            assign sig.fall[i] = ~ref_in[i] & hist_q[i];
        end
    endgenerate

    assign sig.lvl = ref_in;

endmodule

// File: rtl/trig_mode_sel_mux.sv
`timescale 1ns/1ps
module trig_mode_sel_mux
    import trig_mode_sel_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] mode,
    input  cnt_evt_t           evt,
    input  ref_sig_t           sig,
    output logic               trig
);

    trig_mode_e mode_e;
    logic       trig_d;

    generate
        if (FIELD_W < MODE_W) begin : g_narrow
            assign mode_e = trig_mode_e'({{(MODE_W-FIELD_W){1'b0}}, mode});
        end else begin : g_full
            assign mode_e = trig_mode_e'(mode[MODE_W-1:0]);
        end
    endgenerate

    always_comb begin
        unique case (mode_e)
            MD_RESET:  trig_d = evt.rst;
            MD_ENABLE: trig_d = evt.en;
            MD_UPDATE: trig_d = evt.upd;
            MD_CC1:    trig_d = evt.cc1;
            MD_LVL1:   trig_d = sig.lvl[0];
            MD_LVL2:   trig_d = sig.lvl[1];
            MD_LVL3:   trig_d = sig.lvl[2];
            MD_LVL4:   trig_d = sig.lvl[3];
            MD_LVL5:   trig_d = sig.lvl[4];
            MD_LVL6:   trig_d = sig.lvl[5];
            MD_ANY4:   trig_d = sig.rise[3] | sig.fall[3];
            MD_ANY6:   trig_d = sig.rise[5] | sig.fall[5];
            MD_R4_R6:  trig_d = sig.rise[3] | sig.rise[5];
            MD_R4_F6:  trig_d = sig.rise[3] | sig.fall[5];
            MD_R5_R6:  trig_d = sig.rise[4] | sig.rise[5];
            MD_R5_F6:  trig_d = sig.rise[4] | sig.fall[5];
            default:   trig_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig <= 1'b0;
        end else begin
            trig <= trig_d;
        end
    end

endmodule

// File: rtl/trig_mode_sel.sv
`timescale 1ns/1ps
module trig_mode_sel
    import trig_mode_sel_pkg::*;
#(
    parameter bit HAS_AUX = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_rst_evt,
    input  logic               cnt_en,
    input  logic               cnt_upd_evt,
    input  logic               cc1_match,
    input  logic [NUM_REF-1:0] oc_ref,
    input  logic               ctrl_we,
    input  logic [REG_W-1:0]   ctrl_wdata,
    output logic [REG_W-1:0]   ctrl_rdata,
    output logic               trig_main,
    output logic               trig_aux
);

    localparam int MAIN_W   = 3;
    localparam int MAIN_LSB = 4;
    localparam int AUX_W    = MODE_W;
    localparam int AUX_LSB  = 20;

    logic [MAIN_W-1:0] main_mode;
    logic [AUX_W-1:0]  aux_mode;
    cnt_evt_t          evt;
    ref_sig_t          sig;

    assign evt = '{rst: cnt_rst_evt, en: cnt_en, upd: cnt_upd_evt, cc1: cc1_match};

    trig_mode_sel_ctrl #(
        .HAS_AUX (HAS_AUX),
        .MAIN_LSB(MAIN_LSB),
        .MAIN_W  (MAIN_W),
        .AUX_LSB (AUX_LSB),
        .AUX_W   (AUX_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wdata    (ctrl_wdata),
        .main_mode(main_mode),
        .aux_mode (aux_mode),
        .rdata    (ctrl_rdata)
    );

    trig_mode_sel_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_in(oc_ref),
        .sig   (sig)
    );

    trig_mode_sel_mux #(.FIELD_W(MAIN_W)) main_mux_i (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (main_mode),
        .evt  (evt),
        .sig  (sig),
        .trig (trig_main)
    );

    trig_mode_sel_mux #(.FIELD_W(AUX_W)) aux_mux_i (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (aux_mode),
        .evt  (evt),
        .sig  (sig),
        .trig (trig_aux)
    );

endmodule

// File: rtl/trig_mode_sel_chk.sv
`timescale 1ns/1ps
module trig_mode_sel_chk #(
    parameter bit HAS_AUX = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cnt_upd_evt,
    input logic [5:0]  oc_ref,
    input logic        ctrl_we,
    input logic [31:0] ctrl_wdata,
    input logic [31:0] ctrl_rdata,
    input logic        trig_main,
    input logic        trig_aux
);

    // R2: main field follows a write after one clock
    a_r2_main_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rdata[6:4] == $past(ctrl_wdata[6:4]));

    // R2 / R3: auxiliary field takes the write, or stays zero without the field
    a_r3_aux_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rdata[23:20] == (HAS_AUX ? $past(ctrl_wdata[23:20]) : 4'd0));

    // R1: bits outside both fields always read zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata & 32'hFF0F_FF8F) == 32'd0);

    // R4 / R10: update mode on both outputs follows the update event one clock later
    a_r4_main_update: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_rdata[6:4]) == 3'd2 |-> trig_main == $past(cnt_upd_evt));
    a_r10_aux_update: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_rdata[23:20]) == 4'd2 |-> trig_aux == $past(cnt_upd_evt));

    // R6: level mode of the first compare reference
    a_r6_main_level: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_rdata[6:4]) == 3'd4 |-> trig_main == $past(oc_ref[0]));

    // R8: rise of reference 4 or rise of reference 6
    a_r8_rise_or_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_rdata[23:20]) == 4'd12 |->
            trig_aux == (($past(oc_ref[3]) & !$past(oc_ref[3], 2)) |
                         ($past(oc_ref[5]) & !$past(oc_ref[5], 2))));

endmodule

bind trig_mode_sel trig_mode_sel_chk #(.HAS_AUX(HAS_AUX)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_upd_evt(cnt_upd_evt),
    .oc_ref     (oc_ref),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .trig_main  (trig_main),
    .trig_aux   (trig_aux)
);

// File: tb/trig_mode_sel_tb_top.sv
`timescale 1ns/1ps
module trig_mode_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_rst = 1'b0, ev_en = 1'b0, ev_upd = 1'b0, ev_cc1 = 1'b0;
    logic [5:0]  oc = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_a, rd_b;
    logic        tm_a, ta_a, tm_b, ta_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    trig_mode_sel #(.HAS_AUX(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_rst_evt(ev_rst), .cnt_en(ev_en),
        .cnt_upd_evt(ev_upd), .cc1_match(ev_cc1), .oc_ref(oc),
        .ctrl_we(we), .ctrl_wdata(wdata), .ctrl_rdata(rd_a),
        .trig_main(tm_a), .trig_aux(ta_a)
    );

    trig_mode_sel #(.HAS_AUX(1'b0)) dut_noaux_i (
        .clk(clk), .rst_n(rst_n), .cnt_rst_evt(ev_rst), .cnt_en(ev_en),
        .cnt_upd_evt(ev_upd), .cc1_match(ev_cc1), .oc_ref(oc),
        .ctrl_we(we), .ctrl_wdata(wdata), .ctrl_rdata(rd_b),
        .trig_main(tm_b), .trig_aux(ta_b)
    );

    // Row: main[24:22] aux[21:18] prev_ref[17:12] now_ref[11:6]
    //      events{rst,en,upd,cc1}[5:2] exp_main[1] exp_aux[0]
    localparam int NROW = 18;
    localparam logic [24:0] VEC [NROW] = '{
        {3'd0, 4'd2,  6'h00, 6'h00, 4'b1000, 1'b1, 1'b0},  // R4 reset event
        {3'd1, 4'd0,  6'h00, 6'h00, 4'b0100, 1'b1, 1'b0},  // R4 enable
        {3'd2, 4'd2,  6'h00, 6'h00, 4'b0010, 1'b1, 1'b1},  // R4 R10 update both
        {3'd3, 4'd1,  6'h00, 6'h00, 4'b0001, 1'b1, 1'b0},  // R5 cc1 match
        {3'd4, 4'd8,  6'h00, 6'h11, 4'b0000, 1'b1, 1'b1},  // R6 ref1, ref5
        {3'd7, 4'd9,  6'h00, 6'h08, 4'b0000, 1'b1, 1'b0},  // R6 ref4, ref6
        {3'd5, 4'd9,  6'h00, 6'h22, 4'b0000, 1'b1, 1'b1},  // R6 ref2, ref6
        {3'd6, 4'd10, 6'h08, 6'h00, 4'b0000, 1'b0, 1'b1},  // R7 ref4 fall
        {3'd0, 4'd11, 6'h20, 6'h00, 4'b0000, 1'b0, 1'b1},  // R7 ref6 fall
        {3'd7, 4'd11, 6'h20, 6'h20, 4'b0000, 1'b0, 1'b0},  // R7 no edge
        {3'd7, 4'd12, 6'h00, 6'h28, 4'b0000, 1'b1, 1'b1},  // R9 two rises one pulse
        {3'd0, 4'd12, 6'h20, 6'h00, 4'b0000, 1'b0, 1'b0},  // R8 fall ignored
        {3'd0, 4'd13, 6'h20, 6'h00, 4'b0000, 1'b0, 1'b1},  // R8 ref6 fall
        {3'd0, 4'd13, 6'h00, 6'h20, 4'b0000, 1'b0, 1'b0},  // R8 ref6 rise ignored
        {3'd0, 4'd14, 6'h00, 6'h10, 4'b0000, 1'b0, 1'b1},  // R8 ref5 rise
        {3'd0, 4'd14, 6'h00, 6'h08, 4'b0000, 1'b0, 1'b0},  // R8 ref4 not selected
        {3'd0, 4'd15, 6'h20, 6'h00, 4'b0000, 1'b0, 1'b1},  // R8 ref6 fall
        {3'd0, 4'd15, 6'h10, 6'h00, 4'b0000, 1'b0, 1'b0}   // R8 ref5 fall ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_evt(input logic [3:0] e);
        {ev_rst, ev_en, ev_upd, ev_cc1} = e;
    endtask

    task automatic run_row(input logic [24:0] r, input int idx);
        @(negedge clk);
        we = 1'b1;
        wdata = (32'(r[21:18]) << 20) | (32'(r[24:22]) << 4);
        set_evt(4'b0000);
        oc = r[17:12];
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        oc = r[11:6];
        set_evt(r[5:2]);
        @(negedge clk);
        check($sformatf("row %0d main R4-table", idx), {31'd0, tm_a}, {31'd0, r[1]});
        check($sformatf("row %0d aux table", idx), {31'd0, ta_a}, {31'd0, r[0]});
        set_evt(4'b0000);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected <= 20000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // R11: outputs low and fields clear during reset, even with events active
        set_evt(4'b1110);
        repeat (3) @(negedge clk);
        check("R11 main low in reset", {31'd0, tm_a}, 32'd0);
        check("R11 aux low in reset", {31'd0, ta_a}, 32'd0);
        check("R1 reset read-back", rd_a, 32'd0);
        set_evt(4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: field positions
        we = 1'b1;
        wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        we = 1'b0;
        check("R1 field read-back", rd_a, 32'h00F0_0070);
        // R3: absent auxiliary field ignores write
        check("R3 absent field reads zero", rd_b, 32'h0000_0070);

        for (int i = 0; i < NROW; i++) run_row(VEC[i], i);

        // R2: old mode used in the write cycle, new mode after
        @(negedge clk);
        we = 1'b1;
        wdata = 32'd0;
        @(negedge clk);
        we = 1'b1;
        wdata = 32'h0000_0020;
        ev_upd = 1'b1;
        @(negedge clk);
        we = 1'b0;
        check("R2 old mode in write cycle", {31'd0, tm_a}, 32'd0);
        check("R2 read-back next clock", rd_a, 32'h0000_0020);
        @(negedge clk);
        check("R2 new mode after write", {31'd0, tm_a}, 32'd1);
        ev_upd = 1'b0;

        // R9: held edge gives a single one-clock pulse
        we = 1'b1;
        wdata = 32'h00A0_0000;
        oc = 6'h00;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        oc = 6'h08;
        @(negedge clk);
        check("R9 pulse high", {31'd0, ta_a}, 32'd1);
        @(negedge clk);
        check("R9 pulse ends after one clock", {31'd0, ta_a}, 32'd0);

        // R3: aux code 15 write ignored without the field; rise of ref5 gives no pulse
        we = 1'b1;
        wdata = 32'h00F0_0000;
        oc = 6'h00;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        oc = 6'h10;
        @(negedge clk);
        check("R3 with field pulses", {31'd0, ta_a}, 32'd1);
        check("R3 absent field ignores mode", {31'd0, ta_b}, 32'd0);
        check("R3 absent field read-back", rd_b, 32'd0);

        // R11: reset mid-run clears outputs and fields
        we = 1'b1;
        wdata = 32'h0090_0040;
        @(negedge clk);
        we = 1'b0;
        oc = 6'h21;
        @(negedge clk);
        check("R6 levels before reset", {30'd0, tm_a, ta_a}, 32'd3);
        rst_n = 1'b0;
        #1;
        check("R11 outputs low on reset", {30'd0, tm_a, ta_a}, 32'd0);
        check("R11 fields clear on reset", rd_a, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule